// File: doc/BRIEF.md
# XOR-Encoded Preset Up-Counter

This block is a free-running binary up-counter whose reset value is a nonzero constant, built only from storage flops that can be cleared to zero and never preset. The count is not held directly. The register holds the logical count XORed with the reset constant. Clearing every flop therefore yields the required reset value, and an XOR in each direction translates between the stored word and the logical count.

The decoded logical count drives a debug port, so the true count can be seen instead of only the encoded storage. One bit of the count passes through one more clear-only flop to a single registered output. A parameter selects how reset is applied. In the default asynchronous mode, the reset pin clears the flops at once. In synchronous mode, the pin first passes through two clocked flops, and the result clears the flops on a clock edge.

Top module: `xor_preset_counter`

## Requirements
- R1: While reset is in effect, the logical count on `count_o` is the reset constant, binary 0101010101 (0x155).
- R2: On each rising clock edge outside reset, the logical count rises by exactly one.
- R3: The count wraps modulo 2^10, from 0x3FF to 0x000.
- R4: The stored word always equals the logical count XOR 0x155, so a reset leaves every storage flop at zero.
- R5: `tap_o` equals bit 4 of the logical count as it stood before the latest clock edge, delayed by one flop.
- R6: `tap_o` is 0 while reset is in effect.
- R7: In asynchronous mode, raising `rst` sets the count to 0x155 and `tap_o` to 0 with no clock edge.
- R8: In synchronous mode, `rst` passes through two flops, and the count reacts at the third rising edge after `rst` changes. After a rise the count is loaded with 0x155. After a fall the count reaches 0x156.
- R9: `count_o` shows the decoded logical count on every cycle, not the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all flops update on its rising edge |
| rst | input | 1 | Active-high reset; applied asynchronously or through a two-flop synchronizer, depending on the mode parameter |
| tap_o | output | 1 | Registered copy of bit 4 of the logical count |
| count_o | output | 10 | Decoded logical count (debug) |

## Verification
The assertions assume one thing about timing in asynchronous mode: `rst` falls well away from a rising clock edge, so the first increment after reset is unambiguous. The stimulus keeps to this by changing `rst` a quarter period after an edge. In synchronous mode, the assertions assume only that `rst` holds each level for at least three edges, so that the two synchronizer flops settle before the next change. The bench holds every reset level long enough to meet this.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    typedef enum logic {
        RST_ASYNC = 1'b0,
        RST_SYNC  = 1'b1
    } rst_mode_e;

    localparam int         DEF_W     = 10;
    localparam logic [9:0] DEF_PRE   = 10'h155;
    localparam int         DEF_TAP   = 4;

    // Encode and decode are the same XOR against the reset constant.
    function automatic logic [63:0] xpc_flip(input logic [63:0] v, input logic [63:0] k);
        return v ^ k;
    endfunction

endpackage

// File: rtl/xpc_rst_cond.sv
module xpc_rst_cond #(
    parameter bit SYNC = 1'b0
) (
    input  logic clk,
    input  logic rst_i,
    output logic rst_o
);
    generate
        if (SYNC) begin : g_sync
            logic s1_q, s2_q;
            always_ff @(posedge clk) begin
                s1_q <= rst_i;
                s2_q <= s1_q;
            end
            assign rst_o = s2_q;
        end else begin : g_async
            assign rst_o = rst_i;
        end
    endgenerate
endmodule

// File: rtl/xpc_core.sv
module xpc_core
    import xpc_pkg::*;
#(
    parameter int           W     = DEF_W,
    parameter logic [W-1:0] PRE   = W'(DEF_PRE),
    parameter bit           ASYNC = 1'b1
) (
    input  logic         clk,
    input  logic         rst_eff,
    output logic [W-1:0] logical_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] stored_q;
    logic [W-1:0] stored_d;
    logic [W-1:0] logical;

    always_comb begin
        logical  = W'(xpc_flip(64'(stored_q), 64'(PRE)));
        stored_d = W'(xpc_flip(64'(logical + ONE), 64'(PRE)));
    end

    generate
        if (ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst_eff) begin
                if (rst_eff) stored_q <= '0;
                else         stored_q <= stored_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst_eff) stored_q <= '0;
                else         stored_q <= stored_d;
            end
        end
    endgenerate

    assign logical_o = logical;

    AST_STORE_CLEAR: assert property (@(posedge clk)
        rst_eff |=> (stored_q == '0)); // R4
    AST_RESET_VALUE: assert property (@(posedge clk)
        rst_eff |=> (logical_o == PRE)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> (logical_o == W'($past(logical_o) + ONE))); // R2
endmodule

// File: rtl/xpc_tap.sv
module xpc_tap #(
    parameter bit ASYNC = 1'b1
) (
    input  logic clk,
    input  logic rst_eff,
    input  logic bit_i,
    output logic q_o
);
    generate
        if (ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst_eff) begin
                if (rst_eff) q_o <= 1'b0;
                else         q_o <= bit_i;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst_eff) q_o <= 1'b0;
                else         q_o <= bit_i;
            end
        end
    endgenerate

    AST_TAP_FOLLOW: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> (q_o == $past(bit_i))); // R5
    AST_TAP_CLEAR: assert property (@(posedge clk)
        rst_eff |=> (q_o == 1'b0)); // R6
endmodule

// File: rtl/xor_preset_counter.sv
module xor_preset_counter
    import xpc_pkg::*;
#(
    parameter int           CNT_W    = DEF_W,
    parameter logic [CNT_W-1:0] PRE_VAL = CNT_W'(DEF_PRE),
    parameter int           TAP_IDX  = DEF_TAP,
    parameter rst_mode_e    RST_MODE = RST_ASYNC
) (
    input  logic             clk,
    input  logic             rst,
    output logic             tap_o,
    output logic [CNT_W-1:0] count_o
);
    localparam bit IS_ASYNC = (RST_MODE == RST_ASYNC);

    logic rst_eff;

    xpc_rst_cond #(.SYNC(!IS_ASYNC)) u_rst (
        .clk   (clk),
        .rst_i (rst),
        .rst_o (rst_eff)
    );

    xpc_core #(.W(CNT_W), .PRE(PRE_VAL), .ASYNC(IS_ASYNC)) u_core (
        .clk       (clk),
        .rst_eff   (rst_eff),
        .logical_o (count_o)
    );

    xpc_tap #(.ASYNC(IS_ASYNC)) u_tap (
        .clk     (clk),
        .rst_eff (rst_eff),
        .bit_i   (count_o[TAP_IDX]),
        .q_o     (tap_o)
    );
endmodule

// File: tb/tb_xor_preset_counter.sv
module tb_xor_preset_counter;
    import xpc_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [9:0] PRE = 10'h155;

    logic       clk = 1'b0;
    logic       rst_a = 1'b0;
    logic       rst_s = 1'b1;
    logic       tap_a, tap_s;
    logic [9:0] cnt_a, cnt_s;

    int n_run  = 0;
    int n_fail = 0;

    logic [9:0] exp_cnt;
    logic       exp_tap;

    always #(CLK_P/2) clk = ~clk;

    xor_preset_counter #(.RST_MODE(RST_ASYNC)) dut (
        .clk(clk), .rst(rst_a), .tap_o(tap_a), .count_o(cnt_a));

    xor_preset_counter #(.RST_MODE(RST_SYNC)) dut_sync (
        .clk(clk), .rst(rst_s), .tap_o(tap_s), .count_o(cnt_s));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Advance to a quarter period after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    // Model one edge of the async counter outside reset.
    task automatic step_model();
        exp_tap = exp_cnt[4];
        exp_cnt = exp_cnt + 10'd1;
    endtask

    task automatic t_async_reset();
        tick();
        rst_a = 1'b1;
        #1;
        chk("R7 async reset without edge, count", 32'(cnt_a), 32'(PRE));
        chk("R7 async reset without edge, tap", 32'(tap_a), 32'd0);
        tick(); tick();
        chk("R1 count held during reset", 32'(cnt_a), 32'(PRE));
        chk("R6 tap held low during reset", 32'(tap_a), 32'd0);
        chk("R4 cleared storage decodes to reset constant", 32'(cnt_a), 32'h155);
        exp_cnt = PRE;
        exp_tap = 1'b0;
    endtask

    task automatic t_count(input int n);
        int bad_c = 0;
        int bad_t = 0;
        rst_a = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            step_model();
            if (cnt_a !== exp_cnt) begin
                bad_c++;
                chk("R2/R9 count step", 32'(cnt_a), 32'(exp_cnt));
            end
            if (tap_a !== exp_tap) begin
                bad_t++;
                chk("R5 tap follows bit 4", 32'(tap_a), 32'(exp_tap));
            end
        end
        chk("R2 count sequence clean", 32'(bad_c), 32'd0);
        chk("R5 tap sequence clean", 32'(bad_t), 32'd0);
        chk("R9 debug port shows logical count", 32'(cnt_a), 32'(exp_cnt));
    endtask

    task automatic t_wrap();
        int guard = 0;
        while (exp_cnt != 10'h3FF && guard < 1100) begin
            tick();
            step_model();
            guard++;
            if (cnt_a !== exp_cnt) chk("R2 count before wrap", 32'(cnt_a), 32'(exp_cnt));
        end
        chk("R3 reached top value", 32'(cnt_a), 32'h3FF);
        tick();
        step_model();
        chk("R3 wrap to zero", 32'(cnt_a), 32'h000);
        chk("R5 tap after wrap", 32'(tap_a), 32'd1);
        tick();
        step_model();
        chk("R3 counting resumes after wrap", 32'(cnt_a), 32'h001);
    endtask

    task automatic t_async_mid_reset();
        rst_a = 1'b1;
        #1;
        chk("R7 mid-run reset immediate", 32'(cnt_a), 32'(PRE));
        chk("R6 mid-run reset clears tap", 32'(tap_a), 32'd0);
        tick();
        rst_a = 1'b0;
        exp_cnt = PRE;
        exp_tap = 1'b0;
        tick();
        step_model();
        chk("R2 first step after release", 32'(cnt_a), 32'h156);
        chk("R5 tap takes bit 4 of reset constant", 32'(tap_a), 32'd1);
    endtask

    task automatic t_sync_mode();
        logic [9:0] v;
        chk("R1 sync count in reset", 32'(cnt_s), 32'(PRE));
        chk("R6 sync tap in reset", 32'(tap_s), 32'd0);
        rst_s = 1'b0;
        tick();
        chk("R8 release edge 1 still reset", 32'(cnt_s), 32'(PRE));
        tick();
        chk("R8 release edge 2 still reset", 32'(cnt_s), 32'(PRE));
        chk("R6 sync tap low at edge 2", 32'(tap_s), 32'd0);
        tick();
        chk("R8 release edge 3 counts", 32'(cnt_s), 32'h156);
        chk("R5 sync tap after release", 32'(tap_s), 32'd1);
        for (int i = 0; i < 20; i++) tick();
        v = cnt_s;
        chk("R2 sync mode counted", 32'(v), 32'h156 + 32'd20);
        rst_s = 1'b1;
        #1;
        chk("R8 no immediate sync reset", 32'(cnt_s), 32'(v));
        tick();
        chk("R8 assert edge 1 counts", 32'(cnt_s), 32'(v + 10'd1));
        tick();
        chk("R8 assert edge 2 counts", 32'(cnt_s), 32'(v + 10'd2));
        tick();
        chk("R8 assert edge 3 loads constant", 32'(cnt_s), 32'(PRE));
        chk("R6 sync tap cleared", 32'(tap_s), 32'd0);
    endtask

    initial begin
        #1;
        rst_a = 1'b1;
        repeat (4) tick();
        t_async_reset();
        t_count(40);
        t_wrap();
        t_async_mid_reset();
        t_sync_mode();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule